// File: doc/BRIEF.md
# Segmented-Access Binary CAM Core

A small binary content-addressable memory of 64-bit entries, each with its own valid bit. A host reaches it over a 32-bit data bus. A segment-select input picks which half of a 64-bit word or register a transfer touches. One shared address/control input carries either an entry address or an operation code, and an address/control select input says which of the two it is. The operations are random-access read and write, comparand load and read, compare, write-at-next-free, invalidate, clear-all and a status read.

A bus cycle is one clock in which the cycle-enable strobe is high. All inputs are captured on that clock edge. All results appear on the outputs after that same edge. A single active-address register reports one of three addresses, chosen by the kind of cycle that last ran: the lowest-numbered matching entry after a compare, the slot written after a write-at-next-free, or the entry touched by a random access. It changes only on an enabled cycle. An output-enable input gates it onto the port.

Top module: `seg_cam`

## Requirements
- R1: After reset all valid bits are clear, the comparand is zero, the active-address register holds all ones and `dout` is zero.
- R2: In a random-access cycle, `seg_hi`=0 reaches bits 31..0 of the entry and `seg_hi`=1 reaches bits 63..32. A read returns that half on `dout`. A write stores `din` into that half only and sets the entry's valid bit.
- R3: With `ctl_sel`=0, `ac_in[AW-1:0]` is an entry address and the active address becomes that address. With `ctl_sel`=1, `ac_in` is an opcode: 0x01 comparand access (the segment is selected as in R2; `wr_en`=1 loads, `wr_en`=0 reads), 0x02 compare, 0x03 write-at-next-free, 0x04 invalidate entry `din[AW-1:0]`, 0x05 clear all valid bits, 0x06 status read. Any other opcode changes nothing.
- R4: A compare sets the active address to the lowest-numbered valid entry whose 64 bits equal the comparand.
- R5: A compare with no valid matching entry sets the active address to all ones.
- R6: Write-at-next-free stores the whole comparand into the lowest-numbered invalid entry, sets that entry's valid bit and reports its address. When every entry is valid, nothing is written and the active address becomes all ones.
- R7: The active address changes only in compare, write-at-next-free and random-access cycles. It holds its value while `cyc_en` is low and during other operations.
- R8: `aa_vld` equals `oe`. `aa_out` shows the active address when `oe`=1 and reads zero when `oe`=0.
- R9: A status read with `seg_hi`=0 returns the full flag at bit AW and the next-free address in bits AW-1..0, with the address all ones when the memory is full. With `seg_hi`=1, it returns zero.
- R10: An invalidated entry no longer matches. It becomes available again to write-at-next-free.
- R11: Clear-all empties the memory, so the next write-at-next-free goes to entry 0.
- R12: `dout` changes only on random-access reads, comparand reads and status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Bus cycle enable; inputs are captured on each edge where it is high |
| wr_en | input | 1 | 1 = write transfer, 0 = read transfer |
| seg_hi | input | 1 | Segment select: 0 = bits 31..0, 1 = bits 63..32 |
| ctl_sel | input | 1 | 0 = `ac_in` is an address, 1 = `ac_in` is an opcode |
| ac_in | input | CW (8) | Address or opcode |
| din | input | 32 | Write data |
| oe | input | 1 | Output enable for the active address |
| dout | output | 32 | Registered read data |
| aa_out | output | AW (4) | Active address, zero when disabled |
| aa_vld | output | 1 | Active address is being driven |

## Verification
Every operation's effect, including `aa_out` and `dout`, is due exactly one clock edge after the edge at which `cyc_en` is high. The bench raises `cyc_en` on a falling edge for one period. It then compares both outputs against its reference model on the next falling edge, after the single register stage has loaded. The next-free and match results are combinational in the design, so a cycle that runs right after a write or invalidate already sees the new state, and back-to-back sequences test exactly that. Idle stretches with `cyc_en` low are sampled on each falling edge to show that the active address holds. The state of `oe` is checked on every sample.

// File: rtl/seg_cam.sv
module seg_cam #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int CW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic          wr_en,
  input  logic          seg_hi,
  input  logic          ctl_sel,
  input  logic [CW-1:0] ac_in,
  input  logic [DW-1:0] din,
  input  logic          oe,
  output logic [DW-1:0] dout,
  output logic [AW-1:0] aa_out,
  output logic          aa_vld
);
  localparam logic [CW-1:0] OP_CPR = CW'(1);
  localparam logic [CW-1:0] OP_CMP = CW'(2);
  localparam logic [CW-1:0] OP_NXF = CW'(3);
  localparam logic [CW-1:0] OP_INV = CW'(4);
  localparam logic [CW-1:0] OP_CLR = CW'(5);
  localparam logic [CW-1:0] OP_STA = CW'(6);

  logic [2*DW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld, hit_v;
  logic [2*DW-1:0] cmpd;
  logic [AW-1:0]   aa_q, m_idx, f_idx;
  logic            hit, full;

  wire [AW-1:0] ra     = ac_in[AW-1:0];
  wire          do_ra  = cyc_en && !ctl_sel;
  wire          do_cpr = cyc_en && ctl_sel && ac_in == OP_CPR;
  wire          do_cmp = cyc_en && ctl_sel && ac_in == OP_CMP;
  wire          do_nxf = cyc_en && ctl_sel && ac_in == OP_NXF;
  wire          do_inv = cyc_en && ctl_sel && ac_in == OP_INV;
  wire          do_clr = cyc_en && ctl_sel && ac_in == OP_CLR;
  wire          do_sta = cyc_en && ctl_sel && ac_in == OP_STA;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_v[i] = vld[i] && (mem[i] == cmpd);
  end

  assign hit  = |hit_v;
  assign full = &vld;

  always_comb begin
    m_idx = '1;
    f_idx = '1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_v[i]) m_idx = AW'(i);
      if (!vld[i])  f_idx = AW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (do_ra && wr_en) begin
      if (seg_hi) mem[ra][2*DW-1:DW] <= din;
      else        mem[ra][DW-1:0]    <= din;
    end else if (do_nxf && !full) begin
      mem[f_idx] <= cmpd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      cmpd <= '0;
      aa_q <= '1;
      dout <= '0;
    end else begin
      if (do_ra) begin
        aa_q <= ra;
        if (wr_en) vld[ra] <= 1'b1;
        else       dout <= seg_hi ? mem[ra][2*DW-1:DW] : mem[ra][DW-1:0];
      end
      if (do_cpr) begin
        if (!wr_en)      dout <= seg_hi ? cmpd[2*DW-1:DW] : cmpd[DW-1:0];
        else if (seg_hi) cmpd[2*DW-1:DW] <= din;
        else             cmpd[DW-1:0]    <= din;
      end
      if (do_cmp) aa_q <= hit ? m_idx : '1;
      if (do_nxf) begin
        aa_q <= full ? '1 : f_idx;
        if (!full) vld[f_idx] <= 1'b1;
      end
      if (do_inv) vld[din[AW-1:0]] <= 1'b0;
      if (do_clr) vld <= '0;
      if (do_sta && !wr_en)
        dout <= seg_hi ? '0 : DW'({full, f_idx});
    end
  end

  assign aa_vld = oe;
  assign aa_out = oe ? aa_q : '0;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_ra || do_cmp || do_nxf) |=> $stable(aa_q));
  p_miss_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_cmp && !hit) |=> aa_q == '1);
  p_match_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_cmp && hit) |=> vld[aa_q]);
  p_nxf_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_nxf && full) |=> (aa_q == '1 && $stable(vld)));
  p_nxf_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_nxf && !full) |=> vld[aa_q]);
  p_inv_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    do_inv |=> !vld[$past(din[AW-1:0])]);
  p_clr_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> vld == '0);
  p_dout_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !((do_ra || do_cpr || do_sta) && !wr_en) |=> $stable(dout));
endmodule

// File: tb/tb_seg_cam.sv
module tb_seg_cam;
  logic clk = 0, rst_n = 0, cyc_en = 0, wr_en = 0, seg_hi = 0, ctl_sel = 0, oe = 1;
  logic [7:0]  ac_in = 0;
  logic [31:0] din = 0;
  logic [31:0] dout;
  logic [3:0]  aa_out;
  logic        aa_vld;
  int n_chk = 0, n_bad = 0;

  seg_cam dut (.clk, .rst_n, .cyc_en, .wr_en, .seg_hi, .ctl_sel, .ac_in, .din, .oe,
               .dout, .aa_out, .aa_vld);

  always #4 clk = ~clk;

  logic [63:0] m_mem [16];
  bit   [15:0] m_vld = 0, m_wl = 0, m_wh = 0;
  logic [63:0] m_cmp = 0;
  logic [3:0]  m_aa = 4'hf;
  logic [31:0] m_dout = 0;

  function automatic int low_match();
    for (int i = 0; i < 16; i++) if (m_vld[i] && m_mem[i] == m_cmp) return i;
    return -1;
  endfunction

  function automatic int low_free();
    for (int i = 0; i < 16; i++) if (!m_vld[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    chk(req, {28'd0, aa_out}, oe ? {28'd0, m_aa} : 32'd0, "aa_out");
    chk("R8", {31'd0, aa_vld}, {31'd0, oe}, "aa_vld");
    chk(req, dout, m_dout, "dout");
  endtask

  task automatic op(input bit ctl, input logic [7:0] ac, input bit wr, input bit sg,
                    input logic [31:0] d, input string req);
    int f;
    logic [3:0] a;
    @(negedge clk);
    ctl_sel = ctl; ac_in = ac; wr_en = wr; seg_hi = sg; din = d; cyc_en = 1;
    @(negedge clk);
    cyc_en = 0;
    if (!ctl) begin
      a = ac[3:0];
      m_aa = a;
      if (wr) begin
        if (sg) begin m_mem[a][63:32] = d; m_wh[a] = 1; end
        else    begin m_mem[a][31:0]  = d; m_wl[a] = 1; end
        m_vld[a] = 1;
      end else m_dout = sg ? m_mem[a][63:32] : m_mem[a][31:0];
    end else case (ac)
      8'h01: if (!wr) m_dout = sg ? m_cmp[63:32] : m_cmp[31:0];
             else if (sg) m_cmp[63:32] = d; else m_cmp[31:0] = d;
      8'h02: begin f = low_match(); m_aa = (f < 0) ? 4'hf : 4'(f); end
      8'h03: begin
        f = low_free();
        if (f < 0) m_aa = 4'hf;
        else begin m_mem[f] = m_cmp; m_vld[f] = 1; m_wl[f] = 1; m_wh[f] = 1; m_aa = 4'(f); end
      end
      8'h04: m_vld[d[3:0]] = 0;
      8'h05: m_vld = 0;
      8'h06: if (!wr) begin
        f = low_free();
        m_dout = sg ? 32'd0 : {27'd0, (f < 0), (f < 0) ? 4'hf : 4'(f)};
      end
      default: ;
    endcase
    chk_out(req);
  endtask

  task automatic set_cmp(input logic [63:0] v);
    op(1, 8'h01, 1, 0, v[31:0], "R3");
    op(1, 8'h01, 1, 1, v[63:32], "R3");
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_out("R1");
    op(1, 8'h06, 0, 0, 0, "R1");
    op(1, 8'h01, 0, 1, 0, "R1");

    op(0, 8'd5, 1, 0, 32'h1111_2222, "R2");
    op(0, 8'd5, 1, 1, 32'h3333_4444, "R2");
    op(0, 8'd5, 0, 0, 0, "R2");
    op(0, 8'd5, 0, 1, 0, "R2");
    op(0, 8'd5, 1, 0, 32'hAAAA_0000, "R2");
    op(0, 8'd5, 0, 1, 0, "R2");

    op(0, 8'd9, 1, 0, 32'h0, "R3");
    op(0, 8'd9, 1, 1, 32'h0, "R3");
    set_cmp(64'h3333_4444_AAAA_0000);
    op(1, 8'h02, 0, 0, 0, "R4");
    op(0, 8'd2, 1, 0, 32'hAAAA_0000, "R4");
    op(0, 8'd2, 1, 1, 32'h3333_4444, "R4");
    op(1, 8'h02, 0, 0, 0, "R4");
    set_cmp(64'hDEAD_BEEF_0000_0001);
    op(1, 8'h02, 0, 0, 0, "R5");
    op(1, 8'h77, 1, 0, 32'h5, "R3");
    op(1, 8'h06, 0, 1, 0, "R9");

    op(1, 8'h03, 1, 0, 0, "R6");
    op(1, 8'h06, 0, 0, 0, "R9");
    repeat (14) op(1, 8'h03, 0, 0, 0, "R6");
    op(1, 8'h06, 0, 0, 0, "R9");
    op(1, 8'h03, 0, 0, 0, "R6");

    repeat (4) begin @(negedge clk); chk_out("R7"); end
    op(1, 8'h04, 1, 0, 32'd0, "R7");
    op(1, 8'h02, 0, 0, 0, "R10");
    op(1, 8'h04, 1, 0, 32'd7, "R10");
    op(1, 8'h06, 0, 0, 0, "R10");
    op(1, 8'h03, 0, 0, 0, "R10");
    oe = 0;
    @(negedge clk); chk_out("R8");
    oe = 1;
    op(1, 8'h05, 0, 0, 0, "R11");
    op(1, 8'h03, 0, 0, 0, "R11");
    op(1, 8'h02, 0, 0, 0, "R12");

    for (int k = 0; k < 1500; k++) begin
      int kind = $urandom_range(0, 11);
      logic [3:0] a = 4'($urandom);
      bit sg = 1'($urandom);
      oe = ($urandom_range(0, 7) != 0);
      case (kind)
        0, 1: op(0, {4'd0, a}, 1, sg, $urandom, "R2");
        2: if (sg ? m_wh[a] : m_wl[a]) op(0, {4'd0, a}, 0, sg, 0, "R2");
           else op(0, {4'd0, a}, 1, sg, $urandom_range(0, 3), "R2");
        3: if (m_wl[a] && m_wh[a]) set_cmp(m_mem[a]);
           else set_cmp({32'($urandom_range(0, 3)), 32'($urandom_range(0, 3))});
        4, 5: op(1, 8'h02, 1'($urandom), 0, 0, "R4");
        6: op(1, 8'h03, 0, 0, 0, "R6");
        7: op(1, 8'h04, 1, 0, {28'd0, a}, "R10");
        8: if ($urandom_range(0, 5) == 0) op(1, 8'h05, 0, 0, 0, "R11");
           else op(1, 8'h06, 1'($urandom), sg, 0, "R9");
        9: op(1, 8'h01, 0, sg, 0, "R12");
        10: op(1, 8'($urandom_range(7, 255)), 1'($urandom), sg, $urandom, "R3");
        default: begin @(negedge clk); chk_out("R7"); end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule